// File: doc/BRIEF.md
# Float-to-integer saturating converter

This block turns a single-precision binary floating-point value into a 32-bit integer. The caller chooses signed or unsigned output and supplies a rounding mode that is already resolved. The value is rounded to an integer first, and only then checked against the range of the chosen output type. A value that cannot be represented, an infinity or a NaN gives a fixed clip value and raises the invalid flag. A value that fits but was changed by rounding raises the inexact flag. The two flags are never raised together.

A one-cycle pulse on `start_i` samples the operand, the signed select and the rounding mode. After `LATENCY` clock edges the result and both flags are loaded into output registers, and `done_o` pulses for one cycle. The outputs then keep their values until the next conversion completes. The `LATENCY` parameter selects the structure. A value of 1 gives a single combinational path from operand to output register. A value of 2 adds a register between the alignment shifter and the rounding and saturation logic. Field widths and the integer width are parameters.

Top module: `f2i_convert`

## Requirements
- R1: Reset clears `result_o`, `invalid_o`, `inexact_o` and `done_o`. A `start_i` pulse produces a one-cycle `done_o` exactly `LATENCY` cycles later, together with the new result and flags. These outputs hold their values until the next completion.
- R2: `rnd_mode_i` is encoded as follows: 0 = nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity, 4 = nearest with ties away from zero. Codes 5 to 7 behave as toward zero.
- R3: With `signed_i`=1, a value whose rounded result lies in -2^31..2^31-1 gives that result in two's complement, and `invalid_o` stays 0.
- R4: With `signed_i`=0, a value whose rounded result lies in 0..2^32-1 gives that result. A negative value that rounds to zero gives 0 with `inexact_o` set and `invalid_o` clear. A negative value that rounds to -1 or below is invalid.
- R5: A positive out-of-range value, +infinity, or a NaN of either sign gives 0x7FFFFFFF (signed) or 0xFFFFFFFF (unsigned), with `invalid_o`=1 and `inexact_o`=0.
- R6: A negative out-of-range value or -infinity gives 0x80000000 (signed) or 0 (unsigned), with `invalid_o`=1 and `inexact_o`=0.
- R7: `inexact_o` is 1 exactly when the rounded result differs from the input value and `invalid_o` is 0.
- R8: +0 and -0 convert to 0 with no flags. A subnormal input converts to 0, +1 or -1 according to the rounding mode, and always sets `inexact_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion of the operands present in this cycle |
| fp_i | input | 32 | Single-precision operand (sign, 8-bit exponent, 23-bit fraction) |
| signed_i | input | 1 | 1 = signed integer result, 0 = unsigned |
| rnd_mode_i | input | 3 | Resolved rounding mode, encoded as in R2 |
| result_o | output | 32 | Integer result, possibly clipped |
| invalid_o | output | 1 | Result was not representable and was clipped |
| inexact_o | output | 1 | Result differs from the input value (only when valid) |
| done_o | output | 1 | One-cycle pulse when a new result is loaded |

## Verification
Assertions check several properties on every cycle:
- the fixed distance from `start_i` to `done_o`;
- that invalid and inexact are never raised together;
- that a zero operand always leaves the result and both flags clear;
- that a NaN in signed mode always clips to the positive limit;
- that a non-NaN negative operand in unsigned mode always gives zero.

Only the bench's scenarios can show that each rounding mode picks the correct neighbour for ties and near-ties. They also show that the range limits are judged after rounding, which matters at exactly -2^31, 2^31 and 2^32. The same holds for the unsigned case of a small negative value that rounds to zero. The bench sweeps a grid of exponents around and beyond the integer range, with mantissas chosen to land on ties, for every mode, sign and output type. It compares each result against exact scaled-integer arithmetic.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

   // Resolved rounding mode codes as seen at the block's input
   typedef enum logic [2:0] {
      RND_NEAR_EVEN = 3'd0,
      RND_TO_ZERO   = 3'd1,
      RND_DOWN      = 3'd2,
      RND_UP        = 3'd3,
      RND_NEAR_MAX  = 3'd4
   } rnd_mode_e;

   // Special-value classification of the floating-point operand
   typedef struct packed {
      logic is_zero;
      logic is_inf;
      logic is_nan;
   } fp_kind_t;

endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
   import f2i_pkg::*;
#(
   parameter  int EXP_W = 8,
   parameter  int MAN_W = 23,
   parameter  int INT_W = 32,
   localparam int FP_W  = 1 + EXP_W + MAN_W,
   localparam int SH_W  = $clog2(INT_W + 1)
) (
   input  logic [FP_W-1:0]  fp_i,
   output logic             sign_o,
   output fp_kind_t         kind_o,
   output logic             big_o,          // exponent beyond any integer range
   output logic             tiny_o,         // magnitude below one half
   output logic             half_o,         // magnitude in [0.5, 1)
   output logic             tiny_sticky_o,  // tiny magnitude is nonzero
   output logic [SH_W-1:0]  shamt_o,        // unbiased exponent for the shift path
   output logic [MAN_W:0]   sig_o           // significand with hidden bit
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
   localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(BIAS + INT_W);

   if (INT_W + 2 > BIAS) begin : g_bad_range
      $error("f2i_unpack: exponent field too narrow for INT_W");
   end
   if (SH_W > EXP_W) begin : g_bad_shift
      $error("f2i_unpack: shift amount wider than exponent field");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("f2i_unpack: MAN_W must be at least 2");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_all1;
   logic             exp_zero;
   logic             man_nz;

   always_comb begin
      sign_o   = fp_i[FP_W-1];
      exp_f    = fp_i[FP_W-2 -: EXP_W];
      man_f    = fp_i[MAN_W-1:0];
      exp_all1 = &exp_f;
      exp_zero = ~|exp_f;
      man_nz   = |man_f;

      kind_o.is_zero = exp_zero & ~man_nz;
      kind_o.is_inf  = exp_all1 & ~man_nz;
      kind_o.is_nan  = exp_all1 &  man_nz;

      sig_o         = {~exp_zero, man_f};
      big_o         = exp_f > EXP_TOP;
      tiny_o        = exp_f < EXP_HALF;
      half_o        = exp_f == EXP_HALF;
      tiny_sticky_o = ~exp_zero | man_nz;
      shamt_o       = SH_W'(exp_f - EXP_ONE);
   end

endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align #(
   parameter  int MAN_W = 23,
   parameter  int INT_W = 32,
   localparam int SH_W  = $clog2(INT_W + 1),
   localparam int WIDE_W = MAN_W + INT_W + 1
) (
   input  logic [MAN_W:0]   sig_i,
   input  logic [SH_W-1:0]  shamt_i,
   input  logic             tiny_i,
   input  logic             half_i,
   input  logic             tiny_sticky_i,
   output logic [INT_W:0]   ipart_o,   // truncated integer magnitude, one spare bit
   output logic             rbit_o,    // first dropped bit (weight one half)
   output logic             sticky_o   // OR of all lower dropped bits
);

   // Logarithmic left shifter: stage g shifts by 2**g
   logic [SH_W:0][WIDE_W-1:0] lvl;
   assign lvl[0] = WIDE_W'(sig_i);

   for (genvar g = 0; g < SH_W; g++) begin : g_stage
      assign lvl[g+1] = shamt_i[g] ? (lvl[g] << (1 << g)) : lvl[g];
   end

   logic [WIDE_W-1:0] shifted;
   assign shifted = lvl[SH_W];

   always_comb begin
      if (tiny_i) begin
         ipart_o  = '0;
         rbit_o   = 1'b0;
         sticky_o = tiny_sticky_i;
      end else if (half_i) begin
         ipart_o  = '0;
         rbit_o   = 1'b1;
         sticky_o = |sig_i[MAN_W-1:0];
      end else begin
         ipart_o  = shifted[MAN_W +: INT_W+1];
         rbit_o   = shifted[MAN_W-1];
         sticky_o = |shifted[MAN_W-2:0];
      end
   end

endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
   import f2i_pkg::*;
#(
   parameter  int INT_W = 32,
   localparam int MAG_W = INT_W + 2
) (
   input  logic             sign_i,
   input  fp_kind_t         kind_i,
   input  logic             big_i,
   input  logic [INT_W:0]   ipart_i,
   input  logic             rbit_i,
   input  logic             sticky_i,
   input  logic [2:0]       mode_i,
   input  logic             signed_i,
   output logic [INT_W-1:0] res_o,
   output logic             nv_o,
   output logic             nx_o
);

   localparam logic [MAG_W-1:0] S_POS_LIM = {3'b000, {(INT_W-1){1'b1}}};
   localparam logic [MAG_W-1:0] S_NEG_LIM = {3'b001, {(INT_W-1){1'b0}}};
   localparam logic [MAG_W-1:0] U_POS_LIM = {2'b00, {INT_W{1'b1}}};
   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] UMAX = {INT_W{1'b1}};

   logic             lost;
   logic             inc;
   logic [MAG_W-1:0] mag;
   logic [INT_W-1:0] mag_lo;
   logic             ovf;
   logic             pos_clip;

   // Increment decision from the two dropped-bit summaries
   always_comb begin
      lost = rbit_i | sticky_i;
      case (rnd_mode_e'(mode_i))
         RND_NEAR_EVEN: inc = rbit_i & (sticky_i | ipart_i[0]);
         RND_TO_ZERO:   inc = 1'b0;
         RND_DOWN:      inc = lost & sign_i;
         RND_UP:        inc = lost & ~sign_i;
         RND_NEAR_MAX:  inc = rbit_i;
         default:       inc = 1'b0;
      endcase
      mag    = {1'b0, ipart_i} + MAG_W'(inc);
      mag_lo = mag[INT_W-1:0];
   end

   // Range judged on the rounded magnitude
   always_comb begin
      if (signed_i) ovf = sign_i ? (mag > S_NEG_LIM) : (mag > S_POS_LIM);
      else          ovf = sign_i ? (mag != '0)       : (mag > U_POS_LIM);
      nv_o     = kind_i.is_nan | kind_i.is_inf | big_i | ovf;
      nx_o     = lost & ~nv_o;
      pos_clip = kind_i.is_nan | ~sign_i;
      if (nv_o) begin
         if (pos_clip) res_o = signed_i ? SMAX : UMAX;
         else          res_o = signed_i ? SMIN : '0;
      end else begin
         res_o = sign_i ? (~mag_lo + INT_W'(1)) : mag_lo;
      end
   end

endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
   import f2i_pkg::*;
#(
   parameter  int EXP_W   = 8,
   parameter  int MAN_W   = 23,
   parameter  int INT_W   = 32,
   parameter  int LATENCY = 2,
   localparam int FP_W    = 1 + EXP_W + MAN_W,
   localparam int SH_W    = $clog2(INT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [FP_W-1:0]  fp_i,
   input  logic             signed_i,
   input  logic [2:0]       rnd_mode_i,
   output logic [INT_W-1:0] result_o,
   output logic             invalid_o,
   output logic             inexact_o,
   output logic             done_o
);

   if (LATENCY < 1 || LATENCY > 2) begin : g_bad_latency
      $error("f2i_convert: LATENCY must be 1 or 2");
   end

   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};

   typedef struct packed {
      logic           valid;
      logic           sign;
      fp_kind_t       kind;
      logic           big;
      logic [INT_W:0] ipart;
      logic           rbit;
      logic           sticky;
      logic [2:0]     mode;
      logic           is_signed;
   } mid_t;

   // ---------------- stage A: unpack and align ----------------
   logic            u_sign, u_big, u_tiny, u_half, u_tsticky;
   fp_kind_t        u_kind;
   logic [SH_W-1:0] u_shamt;
   logic [MAN_W:0]  u_sig;
   logic [INT_W:0]  a_ipart;
   logic            a_rbit, a_sticky;

   f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) i_unpack (
      .fp_i          (fp_i),
      .sign_o        (u_sign),
      .kind_o        (u_kind),
      .big_o         (u_big),
      .tiny_o        (u_tiny),
      .half_o        (u_half),
      .tiny_sticky_o (u_tsticky),
      .shamt_o       (u_shamt),
      .sig_o         (u_sig)
   );

   f2i_align #(.MAN_W(MAN_W), .INT_W(INT_W)) i_align (
      .sig_i         (u_sig),
      .shamt_i       (u_shamt),
      .tiny_i        (u_tiny),
      .half_i        (u_half),
      .tiny_sticky_i (u_tsticky),
      .ipart_o       (a_ipart),
      .rbit_o        (a_rbit),
      .sticky_o      (a_sticky)
   );

   mid_t mid_d, mid_q;

   always_comb begin
      mid_d.valid     = start_i;
      mid_d.sign      = u_sign;
      mid_d.kind      = u_kind;
      mid_d.big       = u_big;
      mid_d.ipart     = a_ipart;
      mid_d.rbit      = a_rbit;
      mid_d.sticky    = a_sticky;
      mid_d.mode      = rnd_mode_i;
      mid_d.is_signed = signed_i;
   end

   // ---------------- optional split register ----------------
   if (LATENCY == 2) begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           mid_q <= '0;
         else if (mid_d.valid) mid_q <= mid_d;
         else                  mid_q.valid <= 1'b0;
      end
   end else begin : g_direct
      assign mid_q = mid_d;
   end

   // ---------------- stage B: round and saturate ----------------
   logic [INT_W-1:0] r_res;
   logic             r_nv, r_nx;

   f2i_round #(.INT_W(INT_W)) i_round (
      .sign_i   (mid_q.sign),
      .kind_i   (mid_q.kind),
      .big_i    (mid_q.big),
      .ipart_i  (mid_q.ipart),
      .rbit_i   (mid_q.rbit),
      .sticky_i (mid_q.sticky),
      .mode_i   (mid_q.mode),
      .signed_i (mid_q.is_signed),
      .res_o    (r_res),
      .nv_o     (r_nv),
      .nx_o     (r_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o  <= '0;
         invalid_o <= 1'b0;
         inexact_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= mid_q.valid;
         if (mid_q.valid) begin
            result_o  <= r_res;
            invalid_o <= r_nv;
            inexact_o <= r_nx;
         end
      end
   end

   // ---------------- assertions ----------------
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i, LATENCY));

   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(invalid_o && inexact_o));

   p_zero_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q.valid && mid_q.kind.is_zero) |=>
         (done_o && result_o == '0 && !invalid_o && !inexact_o));

   p_nan_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q.valid && mid_q.kind.is_nan && mid_q.is_signed) |=>
         (result_o == SMAX && invalid_o));

   p_unsigned_negative_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q.valid && !mid_q.is_signed && mid_q.sign && !mid_q.kind.is_nan) |=>
         (result_o == '0));

endmodule

// File: tb/test_f2i_convert.sv
`timescale 1ns/1ps
module test_f2i_convert;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] fp = '0;
   logic        sg = 1'b0;
   logic [2:0]  mode = '0;
   logic [31:0] result;
   logic        invalid, inexact, done;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   f2i_convert #(.LATENCY(LAT)) i_f2i_convert (
      .clk(clk), .rst_n(rst_n), .start_i(start), .fp_i(fp), .signed_i(sg),
      .rnd_mode_i(mode), .result_o(result), .invalid_o(invalid),
      .inexact_o(inexact), .done_o(done)
   );

   task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   // Reference: exact scaled-integer arithmetic on value = sig * 2**-k
   function automatic void model(input logic [31:0] f, input logic sgn, input logic [2:0] rm,
                                 output logic [31:0] res, output logic nv, output logic nx);
      logic   s;
      int     e, k;
      longint sig, fl, rem, half, mag, v;
      bit     exact, below, tie, above, huge, inc;
      s = f[31]; e = int'(f[30:23]);
      res = '0; nv = 1'b0; nx = 1'b0;
      if (e == 255) begin
         nv = 1'b1;
         if (f[22:0] != 0 || !s) res = sgn ? 32'h7FFFFFFF : 32'hFFFFFFFF;
         else                    res = sgn ? 32'h80000000 : 32'h0;
         return;
      end
      if (e == 0 && f[22:0] == 0) return;
      sig = (e == 0) ? longint'(f[22:0]) : longint'({1'b1, f[22:0]});
      k = (e == 0) ? 149 : 150 - e;
      exact = 0; below = 0; tie = 0; above = 0; huge = 0; fl = 0;
      if (k <= 0) begin
         exact = 1;
         if (-k > 30) huge = 1; else fl = sig << (-k);
      end else if (k > 40) begin
         below = 1;
      end else begin
         fl = sig >> k;
         rem = sig - (fl << k);
         half = longint'(1) << (k - 1);
         if (rem == 0) exact = 1;
         else if (rem < half) below = 1;
         else if (rem == half) tie = 1;
         else above = 1;
      end
      case (rm)
         3'd0: inc = above | (tie & fl[0]);
         3'd2: inc = !exact & s;
         3'd3: inc = !exact & !s;
         3'd4: inc = tie | above;
         default: inc = 0;
      endcase
      mag = fl + longint'(inc);
      v = s ? -mag : mag;
      if (sgn) nv = huge || v > 64'sd2147483647 || v < -64'sd2147483648;
      else     nv = huge || v < 0 || v > 64'sd4294967295;
      if (nv) res = !s ? (sgn ? 32'h7FFFFFFF : 32'hFFFFFFFF) : (sgn ? 32'h80000000 : 32'h0);
      else    res = v[31:0];
      nx = !exact && !nv;
   endfunction

   task automatic run_op(input logic [31:0] f, input logic sgn, input logic [2:0] rm, output int lat);
      @(negedge clk);
      fp = f; sg = sgn; mode = rm; start = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         start = 1'b0;
         lat++;
      end while (!done && lat < 10);
   endtask

   task automatic expect_op(input logic [31:0] f, input logic sgn, input logic [2:0] rm,
                            input logic [31:0] er, input logic env, input logic enx, input string tag);
      int lat;
      run_op(f, sgn, rm, lat);
      check(tag, {result, invalid, inexact}, {er, env, enx});
   endtask

   initial begin
      int lat;
      logic [31:0] held;
      logic [31:0] er;
      logic        env, enx;
      logic [22:0] mans [8];
      mans = '{23'h0, 23'h1, 23'h400000, 23'h400001, 23'h3FFFFF, 23'h7FFFFF, 23'h200000, 23'h555555};

      repeat (3) @(negedge clk);
      check("R1 reset", {result, invalid, inexact}, 34'h0);
      check("R1 reset done", {33'h0, done}, 34'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {result, invalid, inexact}, 34'h0);

      // R1 latency and hold
      run_op(32'h3F800000, 1'b1, 3'd0, lat);
      check("R1 latency", 34'(lat), 34'(LAT));
      check("R1 first result", {result, invalid, inexact}, {32'd1, 1'b0, 1'b0});
      held = result;
      @(negedge clk);
      check("R1 done is a pulse", {33'h0, done}, 34'h0);
      repeat (3) @(negedge clk);
      check("R1 result held", {result, invalid, inexact}, {held, 1'b0, 1'b0});

      // R8 zeros and subnormals
      expect_op(32'h00000000, 1'b1, 3'd0, 32'd0, 1'b0, 1'b0, "R8 +0");
      expect_op(32'h80000000, 1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R8 -0 unsigned");
      expect_op(32'h00000001, 1'b1, 3'd3, 32'd1, 1'b0, 1'b1, "R8 subnormal up");
      expect_op(32'h00000001, 1'b1, 3'd0, 32'd0, 1'b0, 1'b1, "R8 subnormal nearest");
      expect_op(32'h80000001, 1'b1, 3'd2, 32'hFFFFFFFF, 1'b0, 1'b1, "R8 neg subnormal down");

      // R2 rounding modes on 2.5 / -2.5 / 3.5 / 0.5
      expect_op(32'h40200000, 1'b1, 3'd0, 32'd2, 1'b0, 1'b1, "R2 2.5 even");
      expect_op(32'h40200000, 1'b1, 3'd1, 32'd2, 1'b0, 1'b1, "R2 2.5 zero");
      expect_op(32'h40200000, 1'b1, 3'd2, 32'd2, 1'b0, 1'b1, "R2 2.5 down");
      expect_op(32'h40200000, 1'b1, 3'd3, 32'd3, 1'b0, 1'b1, "R2 2.5 up");
      expect_op(32'h40200000, 1'b1, 3'd4, 32'd3, 1'b0, 1'b1, "R2 2.5 max");
      expect_op(32'h40200000, 1'b1, 3'd5, 32'd2, 1'b0, 1'b1, "R2 2.5 code 5");
      expect_op(32'h40600000, 1'b1, 3'd0, 32'd4, 1'b0, 1'b1, "R2 3.5 even");
      expect_op(32'hC0200000, 1'b1, 3'd2, 32'hFFFFFFFD, 1'b0, 1'b1, "R2 -2.5 down");
      expect_op(32'hC0200000, 1'b1, 3'd3, 32'hFFFFFFFE, 1'b0, 1'b1, "R2 -2.5 up");
      expect_op(32'hC0200000, 1'b1, 3'd4, 32'hFFFFFFFD, 1'b0, 1'b1, "R2 -2.5 max");
      expect_op(32'h3F000000, 1'b1, 3'd4, 32'd1, 1'b0, 1'b1, "R2 0.5 max");
      expect_op(32'h3F000000, 1'b0, 3'd7, 32'd0, 1'b0, 1'b1, "R2 0.5 code 7");

      // R3 / R4 boundaries
      expect_op(32'h4EFFFFFF, 1'b1, 3'd1, 32'h7FFFFF80, 1'b0, 1'b0, "R3 largest below 2^31");
      expect_op(32'hCF000000, 1'b1, 3'd0, 32'h80000000, 1'b0, 1'b0, "R3 exactly -2^31");
      expect_op(32'h4F000000, 1'b0, 3'd0, 32'h80000000, 1'b0, 1'b0, "R4 2^31 unsigned");
      expect_op(32'h4F7FFFFF, 1'b0, 3'd0, 32'hFFFFFF00, 1'b0, 1'b0, "R4 largest below 2^32");
      expect_op(32'hBE99999A, 1'b0, 3'd1, 32'd0, 1'b0, 1'b1, "R4 -0.3 toward zero");
      expect_op(32'hBF000000, 1'b0, 3'd0, 32'd0, 1'b0, 1'b1, "R4 -0.5 even");
      expect_op(32'hBF000000, 1'b0, 3'd2, 32'd0, 1'b1, 1'b0, "R4 -0.5 down invalid");

      // R5 / R6 clipping
      expect_op(32'h4F000000, 1'b1, 3'd0, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 2^31 signed");
      expect_op(32'h4F800000, 1'b0, 3'd0, 32'hFFFFFFFF, 1'b1, 1'b0, "R5 2^32 unsigned");
      expect_op(32'h7F800000, 1'b1, 3'd0, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 +inf signed");
      expect_op(32'h7F800000, 1'b0, 3'd0, 32'hFFFFFFFF, 1'b1, 1'b0, "R5 +inf unsigned");
      expect_op(32'h7FC00000, 1'b0, 3'd1, 32'hFFFFFFFF, 1'b1, 1'b0, "R5 qnan unsigned");
      expect_op(32'hFF800001, 1'b1, 3'd2, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 negative snan");
      expect_op(32'hCF000001, 1'b1, 3'd0, 32'h80000000, 1'b1, 1'b0, "R6 below -2^31");
      expect_op(32'hFF800000, 1'b1, 3'd0, 32'h80000000, 1'b1, 1'b0, "R6 -inf signed");
      expect_op(32'hFF800000, 1'b0, 3'd0, 32'h00000000, 1'b1, 1'b0, "R6 -inf unsigned");
      expect_op(32'hBF800000, 1'b0, 3'd1, 32'h00000000, 1'b1, 1'b0, "R6 -1 unsigned");

      // R7 inexact
      expect_op(32'h3F800000, 1'b1, 3'd0, 32'd1, 1'b0, 1'b0, "R7 exact 1.0");
      expect_op(32'h3FE00000, 1'b1, 3'd1, 32'd1, 1'b0, 1'b1, "R7 1.75 toward zero");

      // Sweep: exponents around and past the range, all modes, both signs and types
      for (int e = 100; e <= 165; e++) begin
         for (int mi = 0; mi < 8; mi++) begin
            for (int s = 0; s < 2; s++) begin
               for (int rm = 0; rm < 6; rm++) begin
                  for (int t = 0; t < 2; t++) begin
                     logic [31:0] f;
                     f = {s[0], e[7:0], mans[mi]};
                     model(f, t[0], rm[2:0], er, env, enx);
                     run_op(f, t[0], rm[2:0], lat);
                     check(env ? (s[0] ? "R6 sweep" : "R5 sweep")
                               : (t[0] ? "R3 R7 sweep" : "R4 R7 sweep"),
                           {result, invalid, inexact}, {er, env, enx});
                  end
               end
            end
         end
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule